// File: doc/BRIEF.md
# Data-Line Charge Recycling Controller

This block sequences one programming cycle per display row for a column of digitally driven data lines. When a row starts it captures one new bit per line and compares it with the bit that line held after the previous row. It then runs a fixed series of shared phases. The line drivers are isolated first. A recycling window follows, in which every line whose bit changes is switched onto a shared charge bank. A one-cycle latch strobe then stores the new bits, and finally the drivers are enabled to pull every line fully to its rail.

Lines that are falling (1 to 0) give charge to the bank, and lines that are rising (0 to 1) take charge from it. Both kinds are connected together in the same window. The block reports how many lines of each kind took part in each row. A mode bit, sampled at row start, selects low-power operation, which recycles charge, or conventional operation, which skips the bank entirely. The switches, bank capacitor and line buffers themselves sit outside the block.

Top module: `chargeRecycleCtrl`

## Requirements
- R1: `lineSwitch[i]` is high only while `bankEn` is high, and in that window it is high exactly when line i's new bit differs from its stored previous bit.
- R2: A line whose stored bit is 1 and whose new bit is 0 is a donor, and a line whose stored bit is 0 and whose new bit is 1 is an acceptor. `donorCount` and `acceptorCount` give the number of each and are registered at the end of the recycle phase, so they are valid from the latch cycle onward. They are computed in both modes.
- R3: A line whose new bit equals its stored bit never has its switch enabled.
- R4: After a `rowStart` pulse accepted while idle, the phases run in a fixed order: ISO_LEN isolate cycles with all enables low, REC_LEN recycle cycles with `driveEn` low, one latch cycle, DRV_LEN cycles with `driveEn` high, and then idle.
- R5: `latchEn` is a single-cycle pulse. At that pulse the new bits replace the stored previous bits used by the next row.
- R6: `bankEn` and every `lineSwitch` bit are low for at least one cycle before `driveEn` rises.
- R7: When `lowPower` is 0 at row start (conventional mode), `bankEn` and all `lineSwitch` bits stay low for the whole row. The mode is sampled only at row start.
- R8: A `frameStart` pulse while idle clears every stored previous bit to 0, so in the next row each line with a new bit of 1 is an acceptor.
- R9: For a single line driven with the bit sequence 0,1,0,0,1,1,0 over seven rows after a frame start, the switch fires in rows 1, 2, 4 and 6, and stays off in rows 0, 3 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Clears the stored previous bits (accepted when idle) |
| rowStart | input | 1 | Starts a programming cycle (accepted when idle) |
| lowPower | input | 1 | 1 = recycle charge, 0 = conventional; sampled at rowStart |
| rowData | input | NUM_LINES | New bit for each line |
| lineSwitch | output | NUM_LINES | Per-line bank switch enable |
| bankEn | output | 1 | Shared bank-enable window |
| latchEn | output | 1 | Strobe that stores the new bits |
| driveEn | output | 1 | Line driver enable |
| donorCount | output | CNT_W | Number of falling lines in the last row |
| acceptorCount | output | CNT_W | Number of rising lines in the last row |

## Verification
Rows of random bits in both modes test the per-line XOR gating and the popcounts against a bench model of the stored bits. An all-zero row followed by an all-one row makes every line an acceptor, and the reverse makes every line a donor. These two cases separate the donor and acceptor counts from each other and from a plain toggle count. Repeating the same row shows that unchanged lines stay isolated, and flipping `lowPower` right after row start shows that the mode is held for the whole row. A single line stepped through the seven-row reference sequence, with a mid-stream frame start, checks the reset of the stored bits to 0 and the exact rows in which the switch fires.

// File: rtl/rcPkg.sv
package rcPkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ISOLATE,
    PH_RECYCLE,
    PH_LATCH,
    PH_DRIVE
  } rcPhase_e;

  typedef struct packed {
    logic capture;
    logic clearPrev;
    logic recycle;
    logic recycleEnd;
    logic latch;
    logic drive;
    logic lowPower;
  } rcStrobe_t;
endpackage

// File: rtl/rcControl.sv
module rcControl
  import rcPkg::*;
#(
  parameter int ISO_LEN = 2,
  parameter int REC_LEN = 3,
  parameter int DRV_LEN = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameStart,
  input  logic      rowStart,
  input  logic      lowPower,
  output rcStrobe_t strb
);
  localparam int MAX_LEN = (ISO_LEN > REC_LEN) ? ((ISO_LEN > DRV_LEN) ? ISO_LEN : DRV_LEN)
                                               : ((REC_LEN > DRV_LEN) ? REC_LEN : DRV_LEN);
  localparam int CNT_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  rcPhase_e   phase;
  logic [CNT_W-1:0] phaseCnt;
  logic       lpReg;
  logic       isIdle;

  assign isIdle = (phase == PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      phaseCnt <= '0;
      lpReg    <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (rowStart) begin
          phase    <= PH_ISOLATE;
          phaseCnt <= CNT_W'(ISO_LEN - 1);
          lpReg    <= lowPower;
        end
        PH_ISOLATE: if (phaseCnt == '0) begin
          phase    <= PH_RECYCLE;
          phaseCnt <= CNT_W'(REC_LEN - 1);
        end else phaseCnt <= phaseCnt - 1'b1;
        PH_RECYCLE: if (phaseCnt == '0) phase <= PH_LATCH;
        else phaseCnt <= phaseCnt - 1'b1;
        PH_LATCH: begin
          phase    <= PH_DRIVE;
          phaseCnt <= CNT_W'(DRV_LEN - 1);
        end
        PH_DRIVE: if (phaseCnt == '0) phase <= PH_IDLE;
        else phaseCnt <= phaseCnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.capture    = isIdle && rowStart;
    strb.clearPrev  = isIdle && frameStart;
    strb.recycle    = (phase == PH_RECYCLE);
    strb.recycleEnd = (phase == PH_RECYCLE) && (phaseCnt == '0);
    strb.latch      = (phase == PH_LATCH);
    strb.drive      = (phase == PH_DRIVE);
    strb.lowPower   = lpReg;
  end

  // R5: the latch strobe lasts one cycle and is followed by the drive phase
  assert_latch_then_drive_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.latch |=> (strb.drive && !strb.latch));
endmodule

// File: rtl/rcDatapath.sv
module rcDatapath
  import rcPkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int CNT_W = $clog2(NUM_LINES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rcStrobe_t            strb,
  input  logic [NUM_LINES-1:0] rowData,
  output logic [NUM_LINES-1:0] lineSwitch,
  output logic [CNT_W-1:0]     donorCount,
  output logic [CNT_W-1:0]     acceptorCount
);
  logic [NUM_LINES-1:0] prevBits;
  logic [NUM_LINES-1:0] newBits;
  logic [NUM_LINES-1:0] changed;
  logic [NUM_LINES-1:0] donorVec;
  logic [NUM_LINES-1:0] acceptVec;
  logic [CNT_W-1:0]     donorSum;
  logic [CNT_W-1:0]     acceptSum;
  logic                 bankWindow;

  assign changed    = prevBits ^ newBits;
  assign donorVec   = changed & prevBits;
  assign acceptVec  = changed & newBits;
  assign bankWindow = strb.recycle && strb.lowPower;

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : gLine
      assign lineSwitch[g] = bankWindow & changed[g];
    end
  endgenerate

  always_comb begin
    donorSum  = '0;
    acceptSum = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      donorSum  = donorSum + CNT_W'(donorVec[i]);
      acceptSum = acceptSum + CNT_W'(acceptVec[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevBits      <= '0;
      newBits       <= '0;
      donorCount    <= '0;
      acceptorCount <= '0;
    end else begin
      if (strb.clearPrev)  prevBits <= '0;
      else if (strb.latch) prevBits <= newBits;
      if (strb.capture)    newBits <= rowData;
      if (strb.recycleEnd) begin
        donorCount    <= donorSum;
        acceptorCount <= acceptSum;
      end
    end
  end

  // R2: a line cannot be both a donor and an acceptor in the same row
  assert_donor_acceptor_disjoint_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.recycleEnd |=> (32'(donorCount) + 32'(acceptorCount) <= NUM_LINES));
endmodule

// File: rtl/chargeRecycleCtrl.sv
module chargeRecycleCtrl
  import rcPkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int ISO_LEN   = 2,
  parameter int REC_LEN   = 3,
  parameter int DRV_LEN   = 2,
  localparam int CNT_W    = $clog2(NUM_LINES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameStart,
  input  logic                 rowStart,
  input  logic                 lowPower,
  input  logic [NUM_LINES-1:0] rowData,
  output logic [NUM_LINES-1:0] lineSwitch,
  output logic                 bankEn,
  output logic                 latchEn,
  output logic                 driveEn,
  output logic [CNT_W-1:0]     donorCount,
  output logic [CNT_W-1:0]     acceptorCount
);
  rcStrobe_t strb;

  rcControl #(.ISO_LEN(ISO_LEN), .REC_LEN(REC_LEN), .DRV_LEN(DRV_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .rowStart(rowStart),
    .lowPower(lowPower), .strb(strb)
  );

  rcDatapath #(.NUM_LINES(NUM_LINES)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .rowData(rowData),
    .lineSwitch(lineSwitch), .donorCount(donorCount), .acceptorCount(acceptorCount)
  );

  assign bankEn  = strb.recycle && strb.lowPower;
  assign latchEn = strb.latch;
  assign driveEn = strb.drive;

  // R1: a line switch may only be closed inside the bank window with drivers off
  assert_switch_in_window_R1: assert property (@(posedge clk) disable iff (!rstN)
    (|lineSwitch) |-> (bankEn && !driveEn));

  // R6: bank and switches are open on the cycle before the drivers turn on
  assert_gap_before_drive_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveEn) |-> (!$past(bankEn) && ($past(lineSwitch) == '0)));

  // R4: the drive phase is always entered straight from the latch strobe
  assert_drive_after_latch_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveEn) |-> $past(latchEn));

  // R4: the bank window never coincides with the latch strobe
  assert_bank_not_latch_R4: assert property (@(posedge clk) disable iff (!rstN)
    bankEn |-> !latchEn);
endmodule

// File: tb/tb_chargeRecycleCtrl.sv
module tb_chargeRecycleCtrl;
  localparam int N = 8;
  localparam int CW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0;
  logic rowStart = 1'b0;
  logic lowPower = 1'b0;
  logic [N-1:0] rowData = '0;
  logic [N-1:0] lineSwitch;
  logic bankEn, latchEn, driveEn;
  logic [CW-1:0] donorCount, acceptorCount;

  int nChecks = 0;
  int nFails = 0;
  logic [N-1:0] prevModel = '0;

  chargeRecycleCtrl #(.NUM_LINES(N)) dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .rowStart(rowStart),
    .lowPower(lowPower), .rowData(rowData), .lineSwitch(lineSwitch),
    .bankEn(bankEn), .latchEn(latchEn), .driveEn(driveEn),
    .donorCount(donorCount), .acceptorCount(acceptorCount)
  );

  always #10 clk = ~clk;

  function automatic int popc(input logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one row; returns the switch vector seen in the first recycle cycle
  task automatic doRow(input logic [N-1:0] d, input bit lp, input bit fs, output logic [N-1:0] swSeen);
    logic [N-1:0] chg, expSw;
    @(negedge clk);
    rowStart = 1'b1; rowData = d; lowPower = lp; frameStart = fs;
    if (fs) prevModel = '0;
    chg = prevModel ^ d;
    expSw = lp ? chg : '0;
    @(negedge clk);
    rowStart = 1'b0; frameStart = 1'b0; lowPower = ~lp; rowData = ~d;
    swSeen = '0;
    for (int k = 1; k <= 8; k++) begin
      if (k <= 2) begin
        check(!driveEn && !bankEn && !latchEn && lineSwitch == '0, "R4 isolate",
              {lineSwitch, 5'b0, driveEn, bankEn, latchEn}, 32'h0);
      end else if (k <= 5) begin
        if (k == 3) swSeen = lineSwitch;
        check(lineSwitch == expSw && bankEn == lp && !driveEn,
              lp ? "R1 recycle switches" : "R7 conventional quiet",
              {lineSwitch, 6'b0, bankEn, driveEn}, {expSw, 6'b0, lp, 1'b0});
        if (k == 4)
          check((lineSwitch & ~chg) == '0, "R3 unchanged isolated", lineSwitch & ~chg, 0);
      end else if (k == 6) begin
        check(latchEn && !driveEn && !bankEn && lineSwitch == '0, "R5 R6 latch cycle",
              {lineSwitch, 5'b0, latchEn, driveEn, bankEn}, 32'h4);
        check(int'(donorCount) == popc(chg & prevModel) && int'(acceptorCount) == popc(chg & d),
              "R2 counts", {donorCount, 8'b0, acceptorCount},
              {CW'(popc(chg & prevModel)), 8'b0, CW'(popc(chg & d))});
      end else begin
        check(driveEn && !latchEn && !bankEn && lineSwitch == '0, "R4 drive",
              {lineSwitch, 5'b0, driveEn, latchEn, bankEn}, 32'h4);
      end
      @(negedge clk);
    end
    check(!driveEn && !latchEn && !bankEn, "R4 back to idle", {driveEn, latchEn, bankEn}, 0);
    prevModel = d;
  endtask

  initial begin
    #(20 * 200000);
    nFails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [N-1:0] sw;
    logic seqBits [7];
    logic expFire [7];
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(lineSwitch == '0 && !bankEn && !latchEn && !driveEn, "R4 reset state",
          {lineSwitch, 5'b0, bankEn, latchEn, driveEn}, 0);
    check(donorCount == '0 && acceptorCount == '0, "R2 reset counts", {donorCount, acceptorCount}, 0);
    rstN = 1'b1;

    // R8: after clearing, a row of ones is all acceptors
    doRow('1, 1'b1, 1'b1, sw);
    check(sw == '1, "R8 first row all acceptors", sw, {N{1'b1}});
    // all donors
    doRow('0, 1'b1, 1'b0, sw);
    check(int'(donorCount) == N && acceptorCount == '0, "R2 all donors", donorCount, N);
    // repeat same row: nothing connects
    doRow('0, 1'b1, 1'b0, sw);
    doRow(8'hA5, 1'b1, 1'b0, sw);
    doRow(8'hA5, 1'b1, 1'b0, sw);
    check(sw == '0, "R3 repeated row", sw, 0);
    // conventional mode with toggling data
    doRow(8'h5A, 1'b0, 1'b0, sw);
    check(sw == '0, "R7 conventional row", sw, 0);

    // R9: reference sequence on line 0, other lines randomised
    seqBits = '{0, 1, 0, 0, 1, 1, 0};
    expFire = '{0, 1, 1, 0, 1, 0, 1};
    for (int r = 0; r < 7; r++) begin
      logic [N-1:0] d;
      d = N'($urandom);
      d[0] = seqBits[r];
      doRow(d, 1'b1, r == 0, sw);
      check(sw[0] == expFire[r], "R9 reference sequence", sw[0], expFire[r]);
    end

    // random rows, mixed modes, occasional frame start
    for (int r = 0; r < 200; r++) begin
      doRow(N'($urandom), 1'($urandom_range(0, 3) != 0), $urandom_range(0, 15) == 0, sw);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule